// File: doc/BRIEF.md
# Windowed Raster Timing Generator

This block paces the readout of a rectangular window out of a larger pixel array. From a single pixel clock it produces a frame-valid level, a line-valid level and a one-cycle frame-start pulse. While a pixel is active it also gives the row and column of that pixel, both relative to the window origin and in array coordinates. Each row begins with a run of blank pixel clocks and then carries the active columns. Each frame carries the active rows and then a run of blank rows.

Software programs the block through a parallel write port and can read any register back. There are two independent blanking sets, A and B. A two-bit context word chooses the horizontal set and the vertical set separately. The window, blanking, context and shutter values are held in a pending copy. They move into the working copy only on the clock edge that closes a frame, so a frame never mixes old and new geometry. A launch-edge bit takes effect at once and chooses whether the timing outputs change on the rising or the falling clock edge.

Top module: `sensor_timing_gen`

## Requirements
- R1: After reset the registers read back, by address: 1 context = 0, 2 launch = 0, 3 column start = 0x026, 4 row start = 0x012, 5 column width = 0x284, 6 row height = RST_ROW_WIDTH (default 0x1E0), 7 horizontal blank A = 0xCB, 8 vertical blank A = 0x0B, 9 horizontal blank B = 0xCB, 10 vertical blank B = 0xCB, 11 shutter = 0x1D6. Unmapped addresses read 0.
- R2: Address 0 always reads 0x1229, and writes to it have no effect.
- R3: A horizontal blank value written below 132 is stored and used as 132. Values of 132 or more are kept as written (11 bits).
- R4: A row lasts horizontal blank + column width clocks. Line-valid is low for the first horizontal-blank clocks and high for the next column-width clocks, on active rows only.
- R5: A frame lasts (row height + vertical blank) rows. Frame-valid is high for exactly the first row-height rows. Frame-start is high for one clock per frame, at its first clock.
- R6: Context bit 0 selects the horizontal blank set and bit 1 selects the vertical blank set (0 = A, 1 = B). Each bit acts on its own.
- R7: Writes to addresses 1 and 3 to 11 change the timing only from the next frame start. A write sampled on the same edge that closes a frame is applied one frame later. A write sampled one edge earlier is applied at once.
- R8: While line-valid is high, the row and column indices count from 0 at the window origin, and the array row and column equal row start + row index and column start + column index. While line-valid is low, all four read 0.
- R9: The shutter-width output follows the register only at frame starts.
- R10: Launch bit 0 (address 2) = 0 makes the timing outputs change only on rising clock edges. When it is 1 they change on falling edges. The bit acts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 4 | Register read address |
| rdData | output | 16 | Register read data (pending copy), combinational |
| frameValid | output | 1 | High during the active rows |
| lineValid | output | 1 | High during the active pixels |
| frameStart | output | 1 | One-clock pulse at each frame's first clock |
| rowIdx | output | 11 | Active row index within the window |
| colIdx | output | 11 | Active column index within the window |
| sensorRow | output | 11 | Active row in array coordinates |
| sensorCol | output | 11 | Active column in array coordinates |
| shutterWidth | output | 16 | Working shutter width in rows |

## Verification
A register write and the frame-closing shadow load can land on the same clock edge, and the bench aims at that collision on purpose. It finds the frame-start pulse, counts forward one frame period less one edge, and has the write sampled on that edge. It then requires the following frame to keep the old row period and the frame after it to show the new one. A second write, placed one edge earlier, must take effect in the very next frame, which pins down on which side of the boundary a write falls.

// File: rtl/stg_pkg.sv
package stg_pkg;
  parameter int COORD_W  = 11;
  parameter int VBLANK_W = 15;
  parameter int SHUT_W   = 16;
  parameter int REG_W    = 16;
  parameter int ADDR_W   = 4;

  localparam int HCNT_W = COORD_W + 1;
  localparam int VCNT_W = VBLANK_W + 1;
  localparam logic [COORD_W-1:0] HBLANK_MIN = COORD_W'(132);
  localparam logic [REG_W-1:0]   VERSION_ID = 16'h1229;

  typedef enum logic [ADDR_W-1:0] {
    A_VERSION   = 4'd0,
    A_CONTEXT   = 4'd1,
    A_LAUNCH    = 4'd2,
    A_COL_START = 4'd3,
    A_ROW_START = 4'd4,
    A_COL_WIDTH = 4'd5,
    A_ROW_WIDTH = 4'd6,
    A_HBLANK_A  = 4'd7,
    A_VBLANK_A  = 4'd8,
    A_HBLANK_B  = 4'd9,
    A_VBLANK_B  = 4'd10,
    A_SHUTTER   = 4'd11
  } regAddr_e;

  // working geometry, context already resolved
  typedef struct packed {
    logic [COORD_W-1:0]  rowStart;
    logic [COORD_W-1:0]  colStart;
    logic [COORD_W-1:0]  rowWidth;
    logic [COORD_W-1:0]  colWidth;
    logic [COORD_W-1:0]  hBlank;
    logic [VBLANK_W-1:0] vBlank;
    logic [SHUT_W-1:0]   shutter;
  } actCfg_t;

  // strobes from raster control to datapath
  typedef struct packed {
    logic loadShadow;
    logic activeRow;
    logic activeCol;
    logic frameHead;
  } ctlStrobe_t;

  typedef struct packed {
    logic               fv;
    logic               lv;
    logic               fs;
    logic [COORD_W-1:0] rowIdx;
    logic [COORD_W-1:0] colIdx;
    logic [COORD_W-1:0] sensorRow;
    logic [COORD_W-1:0] sensorCol;
  } rasterOut_t;
endpackage

// File: rtl/stg_ctl.sv
module stg_ctl
  import stg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [COORD_W-1:0]  hBlank,
  input  logic [COORD_W-1:0]  colWidth,
  input  logic [COORD_W-1:0]  rowWidth,
  input  logic [VBLANK_W-1:0] vBlank,
  output ctlStrobe_t          strb,
  output logic [COORD_W-1:0]  rowPos,
  output logic [COORD_W-1:0]  colPos
);
  logic [HCNT_W-1:0] pixCnt;
  logic [VCNT_W-1:0] lineCnt;
  logic [HCNT_W-1:0] hTotal;
  logic [VCNT_W-1:0] vTotal;
  logic [HCNT_W:0]   pixNext;
  logic [VCNT_W:0]   lineNext;
  logic              lastPix;
  logic              lastLine;

  assign hTotal   = HCNT_W'(hBlank) + HCNT_W'(colWidth);
  assign vTotal   = VCNT_W'(rowWidth) + VCNT_W'(vBlank);
  assign pixNext  = {1'b0, pixCnt} + 1'b1;
  assign lineNext = {1'b0, lineCnt} + 1'b1;
  assign lastPix  = pixNext >= {1'b0, hTotal};
  assign lastLine = lineNext >= {1'b0, vTotal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineCnt <= '0;
    end else if (lastPix) begin
      pixCnt  <= '0;
      lineCnt <= lastLine ? '0 : lineNext[VCNT_W-1:0];
    end else begin
      pixCnt  <= pixNext[HCNT_W-1:0];
    end
  end

  always_comb begin
    strb.loadShadow = lastPix && lastLine;
    strb.activeRow  = lineCnt < VCNT_W'(rowWidth);
    strb.activeCol  = pixCnt >= HCNT_W'(hBlank);
    strb.frameHead  = (pixCnt == '0) && (lineCnt == '0);
  end

  assign rowPos = lineCnt[COORD_W-1:0];
  assign colPos = COORD_W'(pixCnt - HCNT_W'(hBlank));

  // R4
  pix_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixCnt < hTotal);

  // R5
  line_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vTotal != '0) |-> (lineCnt < vTotal));

  // R7
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadShadow |=> (pixCnt == '0 && lineCnt == '0));
endmodule

// File: rtl/stg_datapath.sv
module stg_datapath
  import stg_pkg::*;
#(
  parameter logic [COORD_W-1:0]  RST_ROW_START = 11'h012,
  parameter logic [COORD_W-1:0]  RST_COL_START = 11'h026,
  parameter logic [COORD_W-1:0]  RST_ROW_WIDTH = 11'h1E0,
  parameter logic [COORD_W-1:0]  RST_COL_WIDTH = 11'h284,
  parameter logic [COORD_W-1:0]  RST_HBLANK_A  = 11'h0CB,
  parameter logic [COORD_W-1:0]  RST_HBLANK_B  = 11'h0CB,
  parameter logic [VBLANK_W-1:0] RST_VBLANK_A  = 15'h000B,
  parameter logic [VBLANK_W-1:0] RST_VBLANK_B  = 15'h00CB,
  parameter logic [SHUT_W-1:0]   RST_SHUTTER   = 16'h01D6
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [REG_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [REG_W-1:0]   rdData,
  input  ctlStrobe_t         strb,
  input  logic [COORD_W-1:0] rowPos,
  input  logic [COORD_W-1:0] colPos,
  output actCfg_t            act,
  output rasterOut_t         outBus
);
  logic [COORD_W-1:0]  pRowStart, pColStart, pRowWidth, pColWidth;
  logic [COORD_W-1:0]  pHbA, pHbB;
  logic [VBLANK_W-1:0] pVbA, pVbB;
  logic [SHUT_W-1:0]   pShut;
  logic [1:0]          pCtx;
  logic                invertLaunch;
  logic [COORD_W-1:0]  wrCoord;
  logic [COORD_W-1:0]  wrBlank;
  rasterOut_t          nextBus, posBus, negBus;

  assign wrCoord = wrData[COORD_W-1:0];
  assign wrBlank = (wrCoord < HBLANK_MIN) ? HBLANK_MIN : wrCoord;

  // pending register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pRowStart    <= RST_ROW_START;
      pColStart    <= RST_COL_START;
      pRowWidth    <= RST_ROW_WIDTH;
      pColWidth    <= RST_COL_WIDTH;
      pHbA         <= RST_HBLANK_A;
      pHbB         <= RST_HBLANK_B;
      pVbA         <= RST_VBLANK_A;
      pVbB         <= RST_VBLANK_B;
      pShut        <= RST_SHUTTER;
      pCtx         <= 2'b00;
      invertLaunch <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        A_CONTEXT:   pCtx         <= wrData[1:0];
        A_LAUNCH:    invertLaunch <= wrData[0];
        A_COL_START: pColStart    <= wrCoord;
        A_ROW_START: pRowStart    <= wrCoord;
        A_COL_WIDTH: pColWidth    <= wrCoord;
        A_ROW_WIDTH: pRowWidth    <= wrCoord;
        A_HBLANK_A:  pHbA         <= wrBlank;
        A_VBLANK_A:  pVbA         <= wrData[VBLANK_W-1:0];
        A_HBLANK_B:  pHbB         <= wrBlank;
        A_VBLANK_B:  pVbB         <= wrData[VBLANK_W-1:0];
        A_SHUTTER:   pShut        <= wrData[SHUT_W-1:0];
        default:     ;
      endcase
    end
  end

  // working copy, refreshed on the frame-closing edge only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      act.rowStart <= RST_ROW_START;
      act.colStart <= RST_COL_START;
      act.rowWidth <= RST_ROW_WIDTH;
      act.colWidth <= RST_COL_WIDTH;
      act.hBlank   <= RST_HBLANK_A;
      act.vBlank   <= RST_VBLANK_A;
      act.shutter  <= RST_SHUTTER;
    end else if (strb.loadShadow) begin
      act.rowStart <= pRowStart;
      act.colStart <= pColStart;
      act.rowWidth <= pRowWidth;
      act.colWidth <= pColWidth;
      act.hBlank   <= pCtx[0] ? pHbB : pHbA;
      act.vBlank   <= pCtx[1] ? pVbB : pVbA;
      act.shutter  <= pShut;
    end
  end

  always_comb begin
    case (rdAddr)
      A_VERSION:   rdData = VERSION_ID;
      A_CONTEXT:   rdData = REG_W'(pCtx);
      A_LAUNCH:    rdData = REG_W'(invertLaunch);
      A_COL_START: rdData = REG_W'(pColStart);
      A_ROW_START: rdData = REG_W'(pRowStart);
      A_COL_WIDTH: rdData = REG_W'(pColWidth);
      A_ROW_WIDTH: rdData = REG_W'(pRowWidth);
      A_HBLANK_A:  rdData = REG_W'(pHbA);
      A_VBLANK_A:  rdData = REG_W'(pVbA);
      A_HBLANK_B:  rdData = REG_W'(pHbB);
      A_VBLANK_B:  rdData = REG_W'(pVbB);
      A_SHUTTER:   rdData = REG_W'(pShut);
      default:     rdData = '0;
    endcase
  end

  // raster decode
  always_comb begin
    nextBus.fv = strb.activeRow;
    nextBus.lv = strb.activeRow && strb.activeCol;
    nextBus.fs = strb.frameHead;
    if (nextBus.lv) begin
      nextBus.rowIdx    = rowPos;
      nextBus.colIdx    = colPos;
      nextBus.sensorRow = act.rowStart + rowPos;
      nextBus.sensorCol = act.colStart + colPos;
    end else begin
      nextBus.rowIdx    = '0;
      nextBus.colIdx    = '0;
      nextBus.sensorRow = '0;
      nextBus.sensorCol = '0;
    end
  end

  // launch registers, one per clock edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) posBus <= '0;
    else       posBus <= nextBus;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) negBus <= '0;
    else       negBus <= nextBus;
  end

  assign outBus = invertLaunch ? negBus : posBus;

  // R2
  version_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == A_VERSION) |-> (rdData == VERSION_ID));

  // R3
  hblank_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    act.hBlank >= HBLANK_MIN);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadShadow |=> $stable(act));

  // R5
  lv_inside_fv_chk: assert property (@(posedge clk) disable iff (!rstN)
    posBus.lv |-> posBus.fv);

  // R8
  idx_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !posBus.lv |-> (posBus.rowIdx == '0 && posBus.colIdx == '0));
endmodule

// File: rtl/sensor_timing_gen.sv
module sensor_timing_gen
  import stg_pkg::*;
#(
  parameter logic [10:0] RST_ROW_WIDTH = 11'h1E0
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [15:0] wrData,
  input  logic [3:0]  rdAddr,
  output logic [15:0] rdData,
  output logic        frameValid,
  output logic        lineValid,
  output logic        frameStart,
  output logic [10:0] rowIdx,
  output logic [10:0] colIdx,
  output logic [10:0] sensorRow,
  output logic [10:0] sensorCol,
  output logic [15:0] shutterWidth
);
  ctlStrobe_t         strb;
  actCfg_t            act;
  rasterOut_t         outBus;
  logic [COORD_W-1:0] rowPos;
  logic [COORD_W-1:0] colPos;

  stg_ctl i_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .hBlank   (act.hBlank),
    .colWidth (act.colWidth),
    .rowWidth (act.rowWidth),
    .vBlank   (act.vBlank),
    .strb     (strb),
    .rowPos   (rowPos),
    .colPos   (colPos)
  );

  stg_datapath #(.RST_ROW_WIDTH(RST_ROW_WIDTH)) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .strb   (strb),
    .rowPos (rowPos),
    .colPos (colPos),
    .act    (act),
    .outBus (outBus)
  );

  assign frameValid   = outBus.fv;
  assign lineValid    = outBus.lv;
  assign frameStart   = outBus.fs;
  assign rowIdx       = outBus.rowIdx;
  assign colIdx       = outBus.colIdx;
  assign sensorRow    = outBus.sensorRow;
  assign sensorCol    = outBus.sensorCol;
  assign shutterWidth = act.shutter;
endmodule

// File: tb/test_sensor_timing_gen.sv
`timescale 1ns/1ps
module test_sensor_timing_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [3:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        frameValid, lineValid, frameStart;
  logic [10:0] rowIdx, colIdx, sensorRow, sensorCol;
  logic [15:0] shutterWidth;

  int nChk = 0;
  int nFail = 0;
  int mPeriod, mLv, mRises, mFv, mMaxRow, mMaxCol, mLeak;
  int mFirstRow, mFirstCol, mFirstSRow, mFirstSCol;

  always #4 clk = ~clk;

  sensor_timing_gen #(.RST_ROW_WIDTH(11'd2)) i_sensor_timing_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .frameValid(frameValid),
    .lineValid(lineValid), .frameStart(frameStart), .rowIdx(rowIdx),
    .colIdx(colIdx), .sensorRow(sensorRow), .sensorCol(sensorCol),
    .shutterWidth(shutterWidth)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #6;
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = 4'(a); wrData = 16'(d);
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input int a, input int exp);
    rdAddr = 4'(a); #1;
    chk(req, int'(rdData), exp);
  endtask

  task automatic waitFs();
    do tick(); while (!frameStart);
  endtask

  // positioned on a frameStart sample; counts one whole frame
  task automatic measureFrame();
    logic prevLv = 1'b0;
    logic seen = 1'b0;
    mPeriod = 0; mLv = 0; mRises = 0; mFv = 0; mMaxRow = 0; mMaxCol = 0; mLeak = 0;
    mFirstRow = -1; mFirstCol = -1; mFirstSRow = -1; mFirstSCol = -1;
    do begin
      mPeriod++;
      if (frameValid) mFv++;
      if (lineValid) begin
        mLv++;
        if (!prevLv) mRises++;
        if (!seen) begin
          seen = 1'b1;
          mFirstRow = rowIdx; mFirstCol = colIdx;
          mFirstSRow = sensorRow; mFirstSCol = sensorCol;
        end
        if (int'(rowIdx) > mMaxRow) mMaxRow = rowIdx;
        if (int'(colIdx) > mMaxCol) mMaxCol = colIdx;
      end else if (rowIdx != 0 || colIdx != 0 || sensorRow != 0 || sensorCol != 0) begin
        mLeak++;
      end
      prevLv = lineValid;
      tick();
    end while (!frameStart);
  endtask

  task automatic edgeCount(input int n, output int diffs);
    logic a, b;
    diffs = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 a = lineValid; #5 b = lineValid;
      if (a != b) diffs++;
    end
  endtask

  task automatic t_reset();
    @(posedge clk); #2;
    chk("R1 fv in reset", frameValid, 0);
    chk("R1 lv in reset", lineValid, 0);
    @(posedge clk); #1 rstN = 1'b1;
    rdChk("R1 context", 1, 0);
    rdChk("R1 launch", 2, 0);
    rdChk("R1 col start", 3, 'h026);
    rdChk("R1 row start", 4, 'h012);
    rdChk("R1 col width", 5, 'h284);
    rdChk("R1 row height", 6, 2);
    rdChk("R1 hblank A", 7, 'hCB);
    rdChk("R1 vblank A", 8, 'h0B);
    rdChk("R1 hblank B", 9, 'hCB);
    rdChk("R1 vblank B", 10, 'hCB);
    rdChk("R1 shutter", 11, 'h1D6);
    rdChk("R1 unmapped", 14, 0);
    rdChk("R2 version", 0, 'h1229);
    wr(0, 'h5555);
    rdChk("R2 version after write", 0, 'h1229);
  endtask

  task automatic t_shadowAndClamp();
    int runLen = 0;
    wr(3, 10); wr(4, 20); wr(5, 6); wr(6, 3);
    wr(7, 5); wr(8, 2); wr(9, 140); wr(10, 4); wr(11, 'h55);
    rdChk("R3 hblank A clamped", 7, 132);
    rdChk("R3 hblank B kept", 9, 140);
    wr(7, 131); rdChk("R3 131 clamped", 7, 132);
    wr(7, 132); rdChk("R3 132 kept", 7, 132);
    // old geometry must still run in the current frame
    do tick(); while (!lineValid);
    while (lineValid) begin runLen++; tick(); end
    chk("R7 mid-frame row keeps old width", runLen, 'h284);
    chk("R9 shutter before frame start", shutterWidth, 'h1D6);
    waitFs();
    chk("R9 shutter after frame start", shutterWidth, 'h55);
    measureFrame();
    chk("R5 frame period ctx A", mPeriod, 5 * 138);
    chk("R4 lv clocks per frame", mLv, 18);
    chk("R4 lv runs per frame", mRises, 3);
    chk("R5 fv clocks", mFv, 3 * 138);
    chk("R8 first row idx", mFirstRow, 0);
    chk("R8 first col idx", mFirstCol, 0);
    chk("R8 max row idx", mMaxRow, 2);
    chk("R8 max col idx", mMaxCol, 5);
    chk("R8 array row", mFirstSRow, 20);
    chk("R8 array col", mFirstSCol, 10);
    chk("R8 idle indices zero", mLeak, 0);
  endtask

  task automatic t_context(input int ctx, input int period, input int fv);
    wr(1, ctx);
    waitFs();
    measureFrame();
    chk($sformatf("R6 period ctx %0d", ctx), mPeriod, period);
    chk($sformatf("R6 fv ctx %0d", ctx), mFv, fv);
    chk($sformatf("R4 lv ctx %0d", ctx), mLv, 18);
  endtask

  task automatic t_boundaryWrite();
    // positioned on frameStart of a 690-clock frame
    repeat (688) @(posedge clk);
    #1 wrEn = 1'b1; wrAddr = 4'd5; wrData = 16'd4;
    @(posedge clk); #1 wrEn = 1'b0;
    waitFs();
    measureFrame();
    chk("R7 write on closing edge deferred", mPeriod, 690);
    measureFrame();
    chk("R7 deferred write applied", mPeriod, 5 * 136);
    chk("R4 new width lv", mLv, 12);
    // positioned on frameStart of a 680-clock frame
    repeat (677) @(posedge clk);
    #1 wrEn = 1'b1; wrAddr = 4'd5; wrData = 16'd7;
    @(posedge clk); #1 wrEn = 1'b0;
    waitFs();
    measureFrame();
    chk("R7 write one edge earlier applied", mPeriod, 5 * 139);
    chk("R4 width 7 lv", mLv, 21);
  endtask

  task automatic t_launchEdge();
    int d;
    edgeCount(695, d);
    chk("R10 rising-edge launch", d, 0);
    wr(2, 1);
    rdChk("R10 launch readback", 2, 1);
    waitFs();
    edgeCount(695, d);
    chk("R10 falling-edge launch", d, 6);
  endtask

  initial begin
    t_reset();
    t_shadowAndClamp();
    t_context(3, 7 * 146, 3 * 146);
    t_context(1, 5 * 146, 3 * 146);
    t_context(2, 7 * 138, 3 * 138);
    t_context(0, 5 * 138, 3 * 138);
    t_boundaryWrite();
    t_launchEdge();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #(8 * 190000);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule